// File: doc/BRIEF.md
# 32-to-16-bit Bus Width Splitting Bridge

The bridge lets a processor with a 32-bit read/write port act as master on an external system bus that has a 16-bit data path. Each local request is decoded by address window into a transfer mode. A longword window splits every access into two 16-bit bus cycles, high half first. When the lock flag is set, the same window uses four byte-wide cycles instead. A word window moves one 16-bit half of the local longword in a single bus cycle. Local address bit 29 picks which half.

The upper four bits of the external address are not taken from the local address. They come from a small control register file that software changes through separate bit-clear and bit-set writes. This lets one local window reach any 256 MB region of the external bus. The same register file holds the lock flag.

The local side uses two valid/ready streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the bridge is idle. The bridge then holds one response on `rsp_valid` until a clock edge where `rsp_ready` is high. The master may keep `rsp_ready` low for any number of cycles, and the response stays unchanged during that time. The external side uses a strobe with acknowledge and error inputs.

Top module: `bus32to16_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `ext_req` is 0, and both the address nibble and the lock flag are 0.
- R2: The register window is `req_addr[31:24]==8'h82`, with the slot selected by `req_addr[3:2]`. A write to slot 2 clears the nibble bits that are set in `req_wdata[3:0]` and loads the lock flag from `req_wdata[4]`. A write to slot 3 sets the nibble bits that are set in `req_wdata[3:0]`. A read of slot 2 returns `{27'b0, lock, nibble}`, a read of slot 3 returns `{28'b0, nibble}`, and a read of slot 0 or 1 returns 0. Writes to slots 0 and 1 are ignored. A register access starts no external cycle, and its response is valid in the cycle after acceptance.
- R3: During every external cycle, `ext_addr[31:28]` equals the nibble and `ext_addr[27:2]` equals `req_addr[27:2]`.
- R4: Outside the register window, an address with `req_addr[31]=1` and the lock flag clear makes exactly two 16-bit cycles (`ext_byte=0`). The first cycle drives `ext_addr[1]=0` and the second drives `ext_addr[1]=1`. Both cycles drive `ext_addr[0]=req_addr[0]`.
- R5: A split write drives `req_wdata[31:16]` in the first cycle and `req_wdata[15:0]` in the second.
- R6: A split read returns `{first ext_rdata, second ext_rdata}` as one response, given only after the second acknowledge.
- R7: With the lock flag set, the same window makes four cycles with `ext_byte=1` and `ext_addr[1:0]` stepping 0, 1, 2, 3. Cycle k carries local byte `[31-8k:24-8k]` on `ext_wdata[7:0]`, with `ext_wdata[15:8]=0`. For a read, cycle k fills that byte from `ext_rdata[7:0]`.
- R8: An address with `req_addr[31]=0` and `req_addr[28]=1` makes one 16-bit cycle, whatever the lock flag is. If `req_addr[29]=1`, the cycle uses local bits 31:16 and drives `ext_addr[1]=0`. If `req_addr[29]=0`, it uses bits 15:0 and drives `ext_addr[1]=1`. `ext_addr[0]` equals `req_addr[0]`. The unused half of the read data is 0.
- R9: An address with `req_addr[31]=0` and `req_addr[28]=0` gets a response with `rsp_err=1` and `rsp_rdata=0` in the cycle after acceptance, and no external cycle.
- R10: `ext_err` on any cycle ends the access at once. No further cycle starts, and the response carries `rsp_err=1` and `rsp_rdata=0`.
- R11: `ext_req` stays high, with `ext_addr`, `ext_we` and `ext_wdata` stable, until `ext_ack` or `ext_err` is sampled. After that it is low for at least one cycle.
- R12: `req_ready` is low from acceptance until the response is taken. An unaccepted response keeps `rsp_valid`, `rsp_rdata` and `rsp_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Local byte address |
| req_wdata | input | 32 | Local write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Local side takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access ended with an error |
| ext_req | output | 1 | External cycle strobe |
| ext_we | output | 1 | External cycle is a write |
| ext_byte | output | 1 | External cycle is byte wide |
| ext_addr | output | 32 | External address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ack | input | 1 | External cycle completed |
| ext_err | input | 1 | External cycle failed |

## Verification
A wrong phase counter or captured mode appears in the very next external cycle. It shows as a wrong `ext_addr[1:0]`, a wrong `ext_byte`, the wrong half or byte on `ext_wdata`, or the wrong number of strobes before the response. A wrong read-assembly lane appears only at the single response, where a read half or byte lands in the wrong position.

A corrupted nibble or lock flag shows in `ext_addr[31:28]` on the next external access. It also shows in the mode chosen for the next access in the longword window, and in the next read of slots 2 and 3. Error handling is checked by injecting `ext_err` at every phase position, and by confirming that no further strobe follows it.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int LW     = 32;
  localparam int HW     = LW / 2;
  localparam int BW     = 8;
  localparam int NIB_W  = 4;
  localparam int PASS_W = LW - NIB_W;

  typedef enum logic [2:0] {
    MODE_SPLIT = 3'd0,
    MODE_BYTE  = 3'd1,
    MODE_WORD  = 3'd2,
    MODE_REG   = 3'd3,
    MODE_BAD   = 3'd4
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_GAP,
    ST_RESP
  } seq_state_e;

  function automatic logic [1:0] final_phase(xfer_mode_e m);
    case (m)
      MODE_SPLIT: return 2'd1;
      MODE_BYTE:  return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import bridge_pkg::*;
#(
  parameter logic [7:0] REG_WIN = 8'h82
) (
  input  logic [7:0]  addr_top,
  input  logic        lock,
  output xfer_mode_e  mode,
  output logic        word_hi
);
  // addr_top holds local address bits 31:24
  always_comb begin
    if (addr_top == REG_WIN)  mode = MODE_REG;
    else if (addr_top[7])     mode = lock ? MODE_BYTE : MODE_SPLIT;
    else if (addr_top[4])     mode = MODE_WORD;
    else                      mode = MODE_BAD;
  end

  assign word_hi = addr_top[5];
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
  import bridge_pkg::*;
#(
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    slot,
  input  logic [NW:0]   wdata,
  output logic [LW-1:0] rdata,
  output logic [NW-1:0] nibble,
  output logic          lock
);
  localparam logic [1:0] SLOT_CLR = 2'd2;
  localparam logic [1:0] SLOT_SET = 2'd3;
  localparam int         LOCK_BIT = NW;

  logic [NW-1:0] nib_q;
  logic          lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      case (slot)
        SLOT_CLR: begin
          nib_q  <= nib_q & ~wdata[NW-1:0];
          lock_q <= wdata[LOCK_BIT];
        end
        SLOT_SET: nib_q <= nib_q | wdata[NW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (slot)
      SLOT_CLR: begin
        rdata[NW-1:0]   = nib_q;
        rdata[LOCK_BIT] = lock_q;
      end
      SLOT_SET: rdata[NW-1:0] = nib_q;
      default: ;
    endcase
  end

  assign nibble = nib_q;
  assign lock   = lock_q;
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PASS_W-1:0] req_addr_lo,
  input  logic [LW-1:0]     req_wdata,
  input  xfer_mode_e        mode,
  input  logic              word_hi,
  input  logic [LW-1:0]     reg_rdata,
  output logic              reg_wr,
  input  logic [NIB_W-1:0]  nibble,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              ext_req,
  output logic              ext_we,
  output logic              ext_byte,
  output logic [LW-1:0]     ext_addr,
  output logic [HW-1:0]     ext_wdata,
  input  logic [HW-1:0]     ext_rdata,
  input  logic              ext_ack,
  input  logic              ext_err
);
  seq_state_e        st_q;
  xfer_mode_e        mode_q;
  logic              we_q;
  logic              hi_q;
  logic [PASS_W-1:0] a_q;
  logic [LW-1:0]     wd_q;
  logic [LW-1:0]     rd_q;
  logic [LW-1:0]     rd_cap;
  logic [1:0]        ph_q;
  logic [1:0]        lane;
  logic [1:0]        addr_lo2;
  logic              err_q;
  logic              accept;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign reg_wr    = accept && (mode == MODE_REG) && req_write;
  assign lane      = 2'd3 - ph_q;

  // merge the current external read data into its lane
  always_comb begin
    rd_cap = rd_q;
    case (mode_q)
      MODE_SPLIT: begin
        if (ph_q[0]) rd_cap[HW-1:0]  = ext_rdata;
        else         rd_cap[LW-1:HW] = ext_rdata;
      end
      MODE_BYTE:  rd_cap[{lane, 3'b000} +: BW] = ext_rdata[BW-1:0];
      MODE_WORD: begin
        if (hi_q) rd_cap[LW-1:HW] = ext_rdata;
        else      rd_cap[HW-1:0]  = ext_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_SPLIT;
      we_q   <= 1'b0;
      hi_q   <= 1'b0;
      a_q    <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      ph_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q <= mode;
            we_q   <= req_write;
            hi_q   <= word_hi;
            a_q    <= req_addr_lo;
            wd_q   <= req_wdata;
            ph_q   <= '0;
            err_q  <= 1'b0;
            rd_q   <= '0;
            if (mode == MODE_REG) begin
              rd_q <= req_write ? '0 : reg_rdata;
              st_q <= ST_RESP;
            end else if (mode == MODE_BAD) begin
              err_q <= 1'b1;
              st_q  <= ST_RESP;
            end else begin
              st_q <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (ext_err) begin
            err_q <= 1'b1;
            rd_q  <= '0;
            st_q  <= ST_RESP;
          end else if (ext_ack) begin
            if (!we_q) rd_q <= rd_cap;
            if (ph_q == final_phase(mode_q)) begin
              st_q <= ST_RESP;
            end else begin
              ph_q <= ph_q + 2'd1;
              st_q <= ST_GAP;
            end
          end
        end
        ST_GAP:  st_q <= ST_BUS;
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (mode_q)
      MODE_SPLIT: addr_lo2 = {ph_q[0], a_q[0]};
      MODE_BYTE:  addr_lo2 = ph_q;
      default:    addr_lo2 = {~hi_q, a_q[0]};
    endcase
  end

  always_comb begin
    ext_wdata = '0;
    case (mode_q)
      MODE_SPLIT: ext_wdata = ph_q[0] ? wd_q[HW-1:0] : wd_q[LW-1:HW];
      MODE_BYTE:  ext_wdata[BW-1:0] = wd_q[{lane, 3'b000} +: BW];
      default:    ext_wdata = hi_q ? wd_q[LW-1:HW] : wd_q[HW-1:0];
    endcase
  end

  assign ext_req   = (st_q == ST_BUS);
  assign ext_we    = we_q && ext_req;
  assign ext_byte  = (mode_q == MODE_BYTE);
  assign ext_addr  = {nibble, a_q[PASS_W-1:2], addr_lo2};
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rd_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/bus32to16_bridge.sv
module bus32to16_bridge
  import bridge_pkg::*;
#(
  parameter logic [7:0] REG_WIN = 8'h82
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          ext_req,
  output logic          ext_we,
  output logic          ext_byte,
  output logic [31:0]   ext_addr,
  output logic [15:0]   ext_wdata,
  input  logic [15:0]   ext_rdata,
  input  logic          ext_ack,
  input  logic          ext_err
);
  xfer_mode_e       dec_mode;
  logic             dec_hi;
  logic             lock_flag;
  logic [NIB_W-1:0] ext_nib;
  logic [LW-1:0]    reg_rdata;
  logic             reg_wr;

  bridge_decode #(.REG_WIN(REG_WIN)) u_decode (
    .addr_top (req_addr[31:24]),
    .lock     (lock_flag),
    .mode     (dec_mode),
    .word_hi  (dec_hi)
  );

  bridge_ctrl_regs #(.NW(NIB_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .slot   (req_addr[3:2]),
    .wdata  (req_wdata[NIB_W:0]),
    .rdata  (reg_rdata),
    .nibble (ext_nib),
    .lock   (lock_flag)
  );

  bridge_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr_lo (req_addr[PASS_W-1:0]),
    .req_wdata   (req_wdata),
    .mode        (dec_mode),
    .word_hi     (dec_hi),
    .reg_rdata   (reg_rdata),
    .reg_wr      (reg_wr),
    .nibble      (ext_nib),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .ext_req     (ext_req),
    .ext_we      (ext_we),
    .ext_byte    (ext_byte),
    .ext_addr    (ext_addr),
    .ext_wdata   (ext_wdata),
    .ext_rdata   (ext_rdata),
    .ext_ack     (ext_ack),
    .ext_err     (ext_err)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        ext_req,
  input logic        ext_we,
  input logic        ext_byte,
  input logic [31:0] ext_addr,
  input logic [15:0] ext_wdata,
  input logic        ext_ack,
  input logic        ext_err,
  input logic [3:0]  nib
);
  assert_strobe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack && !ext_err |=> ext_req);

  assert_cycle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack && !ext_err |=>
      $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_we) && $stable(ext_byte));

  assert_strobe_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && (ext_ack || ext_err) |=> !ext_req);

  assert_addr_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> ext_addr[31:28] == nib);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req || rsp_valid) |-> !req_ready);

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_byte && ext_we |-> ext_wdata[15:8] == 8'h00);
endmodule

bind bus32to16_bridge bridge_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .ext_req   (ext_req),
  .ext_we    (ext_we),
  .ext_byte  (ext_byte),
  .ext_addr  (ext_addr),
  .ext_wdata (ext_wdata),
  .ext_ack   (ext_ack),
  .ext_err   (ext_err),
  .nib       (ext_nib)
);

// File: tb/test_bus32to16_bridge.sv
module test_bus32to16_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        ext_req, ext_we, ext_byte;
  logic [31:0] ext_addr;
  logic [15:0] ext_wdata;
  logic [15:0] ext_rdata = '0;
  logic        ext_ack = 1'b0, ext_err = 1'b0;

  always #4 clk = ~clk;

  bus32to16_bridge i_bus32to16_bridge (.*);

  int checks = 0;
  int errors = 0;
  int n_log = 0;
  int err_at = -1;
  logic [31:0] log_addr [8];
  logic        log_we   [8];
  logic [15:0] log_wd   [8];
  logic        log_byte [8];
  logic [3:0]  m_nib = 4'h0;
  logic        m_lock = 1'b0;

  function automatic logic [15:0] mem_f(logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5AC3;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // external bus slave model
  initial begin
    forever begin
      @(negedge clk);
      if (ext_req) begin
        if (n_log < 8) begin
          log_addr[n_log] = ext_addr;
          log_we[n_log]   = ext_we;
          log_wd[n_log]   = ext_wdata;
          log_byte[n_log] = ext_byte;
        end
        n_log++;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        ext_rdata = mem_f(ext_addr);
        if (n_log - 1 == err_at) ext_err = 1'b1;
        else                     ext_ack = 1'b1;
        @(negedge clk);
        ext_ack = 1'b0;
        ext_err = 1'b0;
        chk(!ext_req, "R11", "strobe low after completion", {31'b0, ext_req}, 32'd0);
      end
    end
  end

  task automatic access(input bit w, input logic [31:0] a, input logic [31:0] wd, input int e);
    int          md, n_exp, cyc;
    logic [31:0] ea [4];
    logic [15:0] ew [4];
    logic [31:0] exp_rd, base, rd0;
    bit          eb, exp_err;
    string       rq;
    base = {m_nib, a[27:0]};
    eb = 1'b0; exp_err = 1'b0; exp_rd = '0; n_exp = 0;
    if (a[31:24] == 8'h82)  md = 3;
    else if (a[31])         md = m_lock ? 1 : 0;
    else if (a[28])         md = 2;
    else                    md = 4;
    case (md)
      0: begin
        rq = w ? "R5" : "R6"; n_exp = 2;
        for (int i = 0; i < 2; i++) begin
          ea[i] = {base[31:2], i[0], a[0]};
          ew[i] = i[0] ? wd[15:0] : wd[31:16];
        end
        exp_rd = {mem_f(ea[0]), mem_f(ea[1])};
      end
      1: begin
        rq = "R7"; n_exp = 4; eb = 1'b1;
        for (int i = 0; i < 4; i++) begin
          ea[i] = {base[31:2], i[1:0]};
          ew[i] = {8'h00, wd[8*(3-i) +: 8]};
          exp_rd[8*(3-i) +: 8] = mem_f(ea[i]) ^ 16'h0 ? mem_f(ea[i])[7:0] : 8'h00;
        end
      end
      2: begin
        rq = "R8"; n_exp = 1;
        ea[0] = {base[31:2], ~a[29], a[0]};
        ew[0] = a[29] ? wd[31:16] : wd[15:0];
        exp_rd = a[29] ? {mem_f(ea[0]), 16'h0} : {16'h0, mem_f(ea[0])};
      end
      3: begin
        rq = "R2";
        case (a[3:2])
          2'd2: exp_rd = {27'b0, m_lock, m_nib};
          2'd3: exp_rd = {28'b0, m_nib};
          default: exp_rd = '0;
        endcase
      end
      default: begin
        rq = "R9"; exp_err = 1'b1;
      end
    endcase
    if (md <= 2 && e >= 0 && e < n_exp) begin
      n_exp = e + 1; exp_err = 1'b1; rq = "R10";
    end
    if (w || exp_err) exp_rd = '0;

    n_log = 0;
    err_at = (md <= 2) ? e : -1;
    @(negedge clk);
    chk(req_ready, "R12", "ready while idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk(!req_ready, "R12", "not ready after accept", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    if (md >= 3) chk(cyc == 1, rq, "local response latency", cyc, 32'd1);
    repeat ($urandom_range(0, 2)) begin
      rd0 = rsp_rdata;
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd0, "R12", "response held", rsp_rdata, rd0);
    end
    chk(rsp_err == exp_err, rq, "rsp_err", {31'b0, rsp_err}, {31'b0, exp_err});
    chk(rsp_rdata == exp_rd, rq, "rsp_rdata", rsp_rdata, exp_rd);
    chk(n_log == n_exp, rq, "external cycle count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(log_addr[i] == ea[i], (i == 0 && md != 3) ? "R3" : rq, "ext_addr", log_addr[i], ea[i]);
      chk(log_byte[i] == eb, rq, "ext_byte", {31'b0, log_byte[i]}, {31'b0, eb});
      chk(log_we[i] == w, rq, "ext_we", {31'b0, log_we[i]}, {31'b0, w});
      if (w) chk(log_wd[i] == ew[i], rq, "ext_wdata", {16'h0, log_wd[i]}, {16'h0, ew[i]});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    err_at = -1;
    if (md == 3 && w) begin
      if (a[3:2] == 2'd2) begin
        m_nib = m_nib & ~wd[3:0];
        m_lock = wd[4];
      end else if (a[3:2] == 2'd3) begin
        m_nib = m_nib | wd[3:0];
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] a, wd;
    int kind, e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready, "R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    chk(!rsp_valid, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk(!ext_req, "R1", "ext_req after reset", {31'b0, ext_req}, 32'd0);
    access(1'b0, 32'h8200_0008, 32'h0, -1);  // R1 nibble and lock read 0

    // R2 nibble clear then set
    access(1'b1, 32'h8200_0008, 32'h0000_000F, -1);
    access(1'b1, 32'h8200_000C, 32'h0000_000A, -1);
    access(1'b0, 32'h8200_0008, 32'h0, -1);
    access(1'b0, 32'h8200_000C, 32'h0, -1);

    // R8 word window both halves
    access(1'b0, 32'h7000_1000, 32'h0, -1);
    chk(log_addr[0] == 32'hA000_1000, "R8", "high half address", log_addr[0], 32'hA000_1000);
    access(1'b0, 32'h5000_1000, 32'h0, -1);
    chk(log_addr[0] == 32'hA000_1002, "R8", "low half address", log_addr[0], 32'hA000_1002);
    access(1'b1, 32'h7000_2001, 32'hBEEF_1234, -1);
    access(1'b1, 32'h5000_2001, 32'hBEEF_1234, -1);

    // R4 R5 R6 split
    access(1'b1, 32'hC000_0010, 32'h1234_5678, -1);
    access(1'b0, 32'h8000_0021, 32'h0, -1);
    // R10 error on second half and on first half
    access(1'b0, 32'h8000_0020, 32'h0, 1);
    access(1'b1, 32'hC100_0030, 32'hCAFE_F00D, 0);

    // R7 lock and byte cycles
    access(1'b1, 32'h8200_0008, 32'h0000_0010, -1);
    access(1'b1, 32'h9000_0040, 32'hA1B2_C3D4, -1);
    access(1'b0, 32'h9000_0044, 32'h0, -1);
    access(1'b0, 32'hF000_0048, 32'h0, 2);
    access(1'b0, 32'h7000_3000, 32'h0, -1);   // R8 word mode ignores lock

    // R9 unmapped window
    access(1'b0, 32'h2000_0000, 32'h0, -1);
    access(1'b1, 32'h4FFF_FFFC, 32'hFFFF_FFFF, -1);

    // R2 slots 0 and 1 ignore writes and read zero
    access(1'b1, 32'h8200_0000, 32'h0000_001F, -1);
    access(1'b1, 32'h8200_0004, 32'h0000_001F, -1);
    access(1'b0, 32'h8200_0008, 32'h0, -1);
    access(1'b0, 32'h8200_0004, 32'h0, -1);
    access(1'b1, 32'h8200_0008, 32'h0000_0000, -1);

    for (int n = 0; n < 300; n++) begin
      kind = $urandom_range(0, 5);
      a  = $urandom;
      wd = $urandom;
      e  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 3) : -1;
      case (kind)
        0: a = {8'h82, a[23:4], 2'(a[3:2]), a[1:0]};
        1, 2: begin
          a[31] = 1'b1;
          if (a[31:24] == 8'h82) a[24] = 1'b1;
        end
        3, 4: begin a[31] = 1'b0; a[28] = 1'b1; end
        default: begin a[31] = 1'b0; a[28] = 1'b0; end
      endcase
      access($urandom_range(0, 1) == 1, a, wd, e);
    end
    finish_run();
  end
endmodule